// File: doc/BRIEF.md
# Configurable Watchdog Timer

This block is a watchdog that counts ticks of one of two clock-enable sources and emits a single-cycle reset pulse when the count reaches a programmable limit. Software arms the timer by writing an 8-bit mode byte. The byte chooses one of four time-out lengths, whether counting continues while the core is halted, whether it continues while the core is stopped, and which tick source drives the count. The register cannot be read back. Software keeps the system alive by pulsing the refresh strobe before the limit is reached.

A static strap input forces the timer on in both low-power states. Even with the strap set, the timer cannot advance in STOP while the crystal tick is selected, because that source is halted in STOP. When the pulse fires, the mode fields go back to their power-up values and the count restarts from zero.

Top module: `watchdog_mode_timer`

## Requirements
- R1: Mode bits [1:0] set the time-out length in advances of the selected tick: 00 = 256, 01 = 512, 10 = 1024, 11 = 4096.
- R2: After reset, with no write, the time-out is 512 advances (tap 01).
- R3: Bit 2 set allows counting while `halt_i` is high and bit 2 clear stops it. The reset value of bit 2 is 1.
- R4: Bit 3 set allows counting while `stop_i` is high and bit 3 clear stops it. The reset value of bit 3 is 1.
- R5: Bit 4 selects the tick source: 0 selects `rc_tick` (the reset value) and 1 selects `xtal_tick`. The unselected tick has no effect.
- R6: With bit 4 = 1 and `stop_i` high, the count does not advance, whatever bit 3 and the strap say.
- R7: With `strap_always_on` high, counting continues in HALT and STOP regardless of bits 2 and 3. The R6 stall still applies.
- R8: When `halt_i` and `stop_i` are both high, only the STOP rules apply.
- R9: Bits [7:5] of a written byte have no effect.
- R10: `kick` clears the count to zero. A kick in the same cycle as the final advance wins, and no pulse is produced.
- R11: A mode write clears the count to zero, so the new length is counted from zero.
- R12: On time-out, `wd_reset_o` is high for exactly one clock. The following edge restores all mode fields to their reset values and clears the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_wdata | input | 8 | Mode byte to write |
| kick | input | 1 | Refresh strobe; clears the count |
| halt_i | input | 1 | Core is in HALT |
| stop_i | input | 1 | Core is in STOP |
| rc_tick | input | 1 | Count enable from the internal RC source |
| xtal_tick | input | 1 | Count enable from the crystal source |
| strap_always_on | input | 1 | Static strap that keeps the timer running in low-power states |
| wd_reset_o | output | 1 | Registered one-cycle time-out reset pulse |

## Verification
Two events can fall on the same clock edge: a refresh and the advance that would complete the count. The bench provokes this by holding the tick high continuously and raising `kick` for exactly the edge of the final advance. It judges the result by checking that no pulse appears and that a complete new period is then needed before the next pulse. A second collision places a mode write in the middle of a count, and the bench checks that the new period is measured from the write edge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef struct packed {
    logic       src_xtal;
    logic       run_stop;
    logic       run_halt;
    logic [1:0] tap;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);

  localparam mode_t MODE_DEFAULT = '{
    src_xtal: 1'b0,
    run_stop: 1'b1,
    run_halt: 1'b1,
    tap:      2'b01
  };

endpackage

// File: rtl/wdt_mode_reg.sv
module wdt_mode_reg
  import wdt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restore,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output mode_t             mode_q
);

  always_ff @(posedge clk) begin
    if (rst || restore) begin
      mode_q <= MODE_DEFAULT;
    end else if (we) begin
      mode_q <= mode_t'(wdata[MODE_W-1:0]);
    end
  end

endmodule

// File: rtl/wdt_gate.sv
module wdt_gate
  import wdt_pkg::*;
(
  input  mode_t mode,
  input  logic  halt_i,
  input  logic  stop_i,
  input  logic  strap,
  input  logic  rc_tick,
  input  logic  xtal_tick,
  output logic  advance
);

  logic tick_sel;
  logic allowed;

  always_comb begin
    tick_sel = mode.src_xtal ? xtal_tick : rc_tick;
    if (stop_i) begin
      allowed = !mode.src_xtal && (mode.run_stop || strap);
    end else if (halt_i) begin
      allowed = mode.run_halt || strap;
    end else begin
      allowed = 1'b1;
    end
    advance = tick_sel && allowed;
  end

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int LIM0  = 256,
  parameter int LIM1  = 512,
  parameter int LIM2  = 1024,
  parameter int LIM3  = 4096,
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             advance,
  input  logic [1:0]       tap,
  output logic [CNT_W-1:0] cnt_q,
  output logic             fire_q
);

  logic [CNT_W-1:0] last;

  always_comb begin
    unique case (tap)
      2'd0:    last = CNT_W'(LIM0 - 1);
      2'd1:    last = CNT_W'(LIM1 - 1);
      2'd2:    last = CNT_W'(LIM2 - 1);
      default: last = CNT_W'(LIM3 - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q  <= '0;
      fire_q <= 1'b0;
    end else begin
      fire_q <= 1'b0;
      if (advance) begin
        if (cnt_q >= last) begin
          cnt_q  <= '0;
          fire_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/watchdog_mode_timer.sv
module watchdog_mode_timer
  import wdt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LIM0   = 256,
  parameter int LIM1   = 512,
  parameter int LIM2   = 1024,
  parameter int LIM3   = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              kick,
  input  logic              halt_i,
  input  logic              stop_i,
  input  logic              rc_tick,
  input  logic              xtal_tick,
  input  logic              strap_always_on,
  output logic              wd_reset_o
);

  localparam int LIM_MAX01 = (LIM0 > LIM1) ? LIM0 : LIM1;
  localparam int LIM_MAX23 = (LIM2 > LIM3) ? LIM2 : LIM3;
  localparam int LIM_MAX   = (LIM_MAX01 > LIM_MAX23) ? LIM_MAX01 : LIM_MAX23;
  localparam int CNT_W     = $clog2(LIM_MAX);

  mode_t            mode_q;
  logic             adv;
  logic [CNT_W-1:0] cnt_q;
  logic             fire_q;
  logic             clear;

  // Any refresh, write or time-out restarts the count; clearing wins over advancing.
  assign clear = kick || cfg_we || fire_q;

  wdt_mode_reg #(.DATA_W(DATA_W)) u_mode (
    .clk     (clk),
    .rst     (rst),
    .restore (fire_q),
    .we      (cfg_we),
    .wdata   (cfg_wdata),
    .mode_q  (mode_q)
  );

  wdt_gate u_gate (
    .mode      (mode_q),
    .halt_i    (halt_i),
    .stop_i    (stop_i),
    .strap     (strap_always_on),
    .rc_tick   (rc_tick),
    .xtal_tick (xtal_tick),
    .advance   (adv)
  );

  wdt_counter #(
    .LIM0  (LIM0),
    .LIM1  (LIM1),
    .LIM2  (LIM2),
    .LIM3  (LIM3),
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .clear   (clear),
    .advance (adv),
    .tap     (mode_q.tap),
    .cnt_q   (cnt_q),
    .fire_q  (fire_q)
  );

  assign wd_reset_o = fire_q;

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
  import wdt_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_we,
  input logic             kick,
  input logic             halt_i,
  input logic             stop_i,
  input logic             strap_always_on,
  input logic             wd_reset_o,
  input mode_t            mode_q,
  input logic [CNT_W-1:0] cnt_q
);

  logic no_clear;
  assign no_clear = !kick && !cfg_we && !wd_reset_o;

  assert_single_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    wd_reset_o |=> !wd_reset_o);

  assert_defaults_back_R12: assert property (@(posedge clk) disable iff (rst)
    wd_reset_o |=> (mode_q == MODE_DEFAULT) && (cnt_q == '0));

  assert_kick_clears_R10: assert property (@(posedge clk) disable iff (rst)
    kick |=> (cnt_q == '0) && !wd_reset_o);

  assert_write_clears_R11: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (cnt_q == '0));

  assert_xtal_stop_stall_R6: assert property (@(posedge clk) disable iff (rst)
    (stop_i && mode_q.src_xtal && no_clear) |=> $stable(cnt_q) && !wd_reset_o);

  assert_halt_off_stall_R3: assert property (@(posedge clk) disable iff (rst)
    (halt_i && !stop_i && !mode_q.run_halt && !strap_always_on && no_clear)
      |=> $stable(cnt_q) && !wd_reset_o);

  // R8: with both inputs high, a halt enable alone does not let the count move
  assert_stop_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (halt_i && stop_i && !mode_q.run_stop && !strap_always_on && no_clear)
      |=> $stable(cnt_q) && !wd_reset_o);

endmodule

bind watchdog_mode_timer wdt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .cfg_we          (cfg_we),
  .kick            (kick),
  .halt_i          (halt_i),
  .stop_i          (stop_i),
  .strap_always_on (strap_always_on),
  .wd_reset_o      (wd_reset_o),
  .mode_q          (mode_q),
  .cnt_q           (cnt_q)
);

// File: tb/sim_watchdog_mode_timer.sv
`timescale 1ns/1ps
module sim_watchdog_mode_timer;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic       kick = 1'b0;
  logic       halt_i = 1'b0;
  logic       stop_i = 1'b0;
  logic       rc_tick = 1'b0;
  logic       xtal_tick = 1'b0;
  logic       strap_always_on = 1'b0;
  logic       wd_reset_o;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  watchdog_mode_timer u0 (
    .clk             (clk),
    .rst             (rst),
    .cfg_we          (cfg_we),
    .cfg_wdata       (cfg_wdata),
    .kick            (kick),
    .halt_i          (halt_i),
    .stop_i          (stop_i),
    .rc_tick         (rc_tick),
    .xtal_tick       (xtal_tick),
    .strap_always_on (strap_always_on),
    .wd_reset_o      (wd_reset_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  typedef struct packed {
    logic [7:0]  mode;
    logic        wr;
    logic        halt;
    logic        stop;
    logic        strap;
    logic        rc;
    logic        xt;
    logic [12:0] expect_n;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 22;
  // expect_n = 0 means no pulse may appear within the window
  localparam vec_t VT [NV] = '{
    '{8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 13'd512,  4'd2},  // R2 default
    '{8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 13'd256,  4'd1},  // R1
    '{8'h02, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 13'd1024, 4'd1},  // R1
    '{8'h03, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 13'd4096, 4'd1},  // R1
    '{8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 13'd512,  4'd3},  // R3 default on
    '{8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 13'd0,    4'd3},  // R3 off
    '{8'h04, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 13'd256,  4'd3},  // R3 on
    '{8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 13'd512,  4'd4},  // R4 default on
    '{8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 13'd0,    4'd4},  // R4 off
    '{8'h08, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 13'd256,  4'd4},  // R4 on
    '{8'h10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 13'd256,  4'd5},  // R5 crystal
    '{8'h10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 13'd0,    4'd5},  // R5 rc ignored
    '{8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 13'd0,    4'd5},  // R5 xtal ignored
    '{8'h18, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 13'd0,    4'd6},  // R6
    '{8'h18, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 13'd0,    4'd6},  // R6 with strap
    '{8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 13'd256,  4'd7},  // R7 halt
    '{8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 13'd256,  4'd7},  // R7 stop
    '{8'h04, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 13'd0,    4'd8},  // R8 stop wins
    '{8'h08, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 13'd256,  4'd8},  // R8
    '{8'hE0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 13'd256,  4'd9},  // R9
    '{8'hE1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 13'd512,  4'd9},  // R9
    '{8'h20, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 13'd0,    4'd9}   // R9 reserved bit not a halt enable
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cfg_we = 1'b0; kick = 1'b0; halt_i = 1'b0; stop_i = 1'b0;
    rc_tick = 1'b0; xtal_tick = 1'b0; strap_always_on = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic write_mode(input logic [7:0] m);
    cfg_we = 1'b1; cfg_wdata = m;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // counts posedges until the pulse is seen at a negedge sample, up to limit
  task automatic wait_pulse(input int limit, output int n);
    n = 0;
    while (n < limit) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (wd_reset_o) return;
    end
    n = 0;
  endtask

  initial begin
    int n;
    do_reset();
    check(wd_reset_o == 1'b0, "R12 reset state", wd_reset_o, 0);

    for (int i = 0; i < NV; i++) begin
      do_reset();
      if (VT[i].wr) write_mode(VT[i].mode);
      halt_i = VT[i].halt; stop_i = VT[i].stop; strap_always_on = VT[i].strap;
      rc_tick = VT[i].rc; xtal_tick = VT[i].xt;
      wait_pulse((VT[i].expect_n == 0) ? 600 : int'(VT[i].expect_n) + 4, n);
      check(n == int'(VT[i].expect_n), $sformatf("R%0d vector %0d", VT[i].req, i),
            n, int'(VT[i].expect_n));
    end

    // R12: one-cycle pulse, then defaults (512) restored
    do_reset();
    write_mode(8'h00);
    rc_tick = 1'b1;
    wait_pulse(260, n);
    check(n == 256, "R12 first period", n, 256);
    @(negedge clk);
    check(wd_reset_o == 1'b0, "R12 pulse width", wd_reset_o, 0);
    wait_pulse(520, n);
    check(n == 512, "R12 defaults after pulse", n + 1, 513);

    // R10: kick on the final advance edge suppresses the pulse
    do_reset();
    write_mode(8'h00);
    rc_tick = 1'b1;
    repeat (255) @(negedge clk);
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
    check(wd_reset_o == 1'b0, "R10 kick beats final advance", wd_reset_o, 0);
    wait_pulse(260, n);
    check(n == 256, "R10 full period after kick", n, 256);

    // R10: periodic kicks keep the pulse away
    do_reset();
    write_mode(8'h00);
    rc_tick = 1'b1;
    begin
      bit seen = 1'b0;
      for (int k = 0; k < 1000; k++) begin
        kick = (k % 200 == 199);
        @(negedge clk);
        if (wd_reset_o) seen = 1'b1;
      end
      kick = 1'b0;
      check(!seen, "R10 periodic kicks", seen, 0);
    end

    // R11: a mid-count write restarts the period
    do_reset();
    write_mode(8'h00);
    rc_tick = 1'b1;
    repeat (200) @(negedge clk);
    write_mode(8'h00);
    wait_pulse(260, n);
    check(n == 256, "R11 write clears count", n, 256);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule